// File: doc/BRIEF.md
# Hash Engine Control Register Interface

This block is the software-facing front end of a hash accelerator with several algorithm choices. A small register bus sets the algorithm mode, issues start and terminate commands, reports a busy flag, and carries a 64-bit running message length split over two 32-bit registers. The chaining state of the hash is reached through one window register. Each access to the window moves to the next state word, so software can save a partly hashed context and later load it back to continue.

Input data arrives as 32-bit beats on a side port. The compression function is replaced by a stub with defined arithmetic. While an operation is active, each beat adds its value into one state word and advances the length by four bytes. A terminate command starts a finalization phase lasting a fixed number of cycles. When that phase ends, the stub mixes the length into the state and raises the done interrupt. Done, along with three error causes, sits in a write-one-to-clear status register. An enable register selects which status bits drive the single interrupt line.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset every register reads as zero and `irq` is low. The state words hold their initial values: word i = IV_SEED ^ (i * 0x01010101).
- R2: The mode register (offset 0x00) keeps the algorithm code in bits 18:16, the keyed-hash flag in bit 22 and the data-order field in bits 31:26. All other bits read back as zero. Each mode write reloads the initial state words and clears both length registers.
- R3: Each read or write of the window register (0x04) moves to the next state word and wraps after the last one. There are 16 words when the algorithm code is 3 or 4, and 8 words for every other code.
- R4: Any write to the mode register or to the operation register (0x08) returns the window position to word 0.
- R5: Writing 1 to operation bit 0 makes an operation active. While active, each data beat adds its value into word ((length_low >> 2) mod word_count) and raises the 64-bit length by 4, carrying from the low register (0x60) into the high register (0x64).
- R6: A data beat that arrives while no operation is active changes neither the length nor the state, and sets interrupt status bit 0.
- R7: Writing 1 to operation bit 1 during an active operation sets status bit 0 (busy, offset 0x58) for FINAL_CYCLES cycles. After that, every active state word is XORed with length_low and interrupt status bit 2 (done) is set. Starting an operation or feeding it beats never sets done.
- R8: A window access while busy reads as zero, writes nothing, leaves the window position unchanged and sets interrupt status bit 1.
- R9: A terminate with no active operation and no start in the same write, or a terminate while busy, is ignored and sets interrupt status bit 3.
- R10: Writing a one to a bit of the interrupt status register (0x50) clears that bit; other bits are held. The `irq` output is high exactly when some status bit and its matching bit in the enable register (0x54) are both set.
- R11: Software can write both length registers and the state words. Hashing then continues from the written context, with beats placed and counted from the written length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the same cycle as the read request |
| beat_valid | input | 1 | Data beat present |
| beat_data | input | 32 | Data beat value |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default build: 8 narrow words, 16 wide words and four finalization cycles. With these values every algorithm code can be swept, and each sweep walks the whole window one step past the wrap. The short finalization window lets the bench read status on every busy cycle and place a window access inside it. Restoring a length of 0xFFFFFFFC reaches the carry into the high register and the last wide word with two beats. The full 16-value sweep of the interrupt enable and a bit-by-bit clear cover the interrupt line.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;
   localparam logic [7:0] OFS_MODE  = 8'h00;
   localparam logic [7:0] OFS_CHAIN = 8'h04;
   localparam logic [7:0] OFS_OP    = 8'h08;
   localparam logic [7:0] OFS_ISR   = 8'h50;
   localparam logic [7:0] OFS_IER   = 8'h54;
   localparam logic [7:0] OFS_STAT  = 8'h58;
   localparam logic [7:0] OFS_LENLO = 8'h60;
   localparam logic [7:0] OFS_LENHI = 8'h64;

   localparam int NUM_IRQ = 4;
   localparam int IRQ_ORPHAN  = 0;
   localparam int IRQ_WINBUSY = 1;
   localparam int IRQ_DONE    = 2;
   localparam int IRQ_BADTERM = 3;

   typedef struct packed {
      logic [5:0] order;
      logic       keyed;
      logic [2:0] alg;
   } mode_t;

   function automatic logic alg_is_wide(input logic [2:0] a);
      return (a == 3'd3) || (a == 3'd4);
   endfunction
endpackage

// File: rtl/hash_ctl_engine.sv
module hash_ctl_engine #(
   parameter int FINAL_CYCLES = 4,
   parameter int BEAT_BYTES   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode_wr,
   input  logic        op_start,
   input  logic        op_term,
   input  logic        beat_valid,
   input  logic        len_lo_wr,
   input  logic        len_hi_wr,
   input  logic [31:0] wdata,
   output logic        busy,
   output logic        beat_ok,
   output logic        fin_done,
   output logic        err_orphan,
   output logic        err_term,
   output logic [31:0] len_lo,
   output logic [31:0] len_hi
);
   localparam int CNTW = (FINAL_CYCLES > 1) ? $clog2(FINAL_CYCLES) : 1;

   logic            active;
   logic [CNTW-1:0] cnt;
   logic [63:0]     len_q;
   logic            term_ok, start_ok;

   assign start_ok   = op_start && !busy;
   assign term_ok    = op_term && !busy && (active || op_start);
   assign err_term   = op_term && !term_ok;
   assign beat_ok    = beat_valid && active;
   assign err_orphan = beat_valid && !active;
   assign fin_done   = busy && (cnt == '0);
   assign len_lo     = len_q[31:0];
   assign len_hi     = len_q[63:32];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         busy   <= 1'b0;
         cnt    <= '0;
      end else begin
         if (term_ok)       active <= 1'b0;
         else if (start_ok) active <= 1'b1;
         if (term_ok) begin
            busy <= 1'b1;
            cnt  <= CNTW'(FINAL_CYCLES - 1);
         end else if (fin_done) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (mode_wr) begin
         len_q <= '0;
      end else begin
         if (len_lo_wr) len_q[31:0]  <= wdata;
         if (len_hi_wr) len_q[63:32] <= wdata;
         if (!len_lo_wr && !len_hi_wr && beat_ok)
            len_q <= len_q + 64'(BEAT_BYTES);
      end
   end

   // R7
   one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && busy));
   // R7
   busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cnt == CNTW'(FINAL_CYCLES - 1)));
   // R5
   len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && !mode_wr && !len_lo_wr && !len_hi_wr)
      |=> (len_q == $past(len_q) + 64'(BEAT_BYTES)));
   // R6
   orphan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_orphan && !mode_wr && !len_lo_wr && !len_hi_wr) |=> $stable(len_q));
endmodule

// File: rtl/hash_ctl_state.sv
module hash_ctl_state #(
   parameter int          NARROW_WORDS = 8,
   parameter int          WIDE_WORDS   = 16,
   parameter logic [31:0] IV_SEED      = 32'h5A5A0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode_wr,
   input  logic        wide,
   input  logic        idx_clr,
   input  logic        win_rd,
   input  logic        win_wr,
   input  logic [31:0] win_wdata,
   input  logic        busy,
   input  logic        beat_ok,
   input  logic [31:0] beat_data,
   input  logic [31:0] len_lo,
   input  logic        fin_done,
   output logic [31:0] win_rdata,
   output logic        win_err
);
   localparam int IDXW = $clog2(WIDE_WORDS);

   logic [31:0]     words [WIDE_WORDS];
   logic [IDXW-1:0] idx, last_idx, beat_idx;
   logic            win_access, win_go;

   assign last_idx   = wide ? IDXW'(WIDE_WORDS - 1) : IDXW'(NARROW_WORDS - 1);
   assign beat_idx   = len_lo[2 +: IDXW] & last_idx;
   assign win_access = win_rd || win_wr;
   assign win_go     = win_access && !busy;
   assign win_err    = win_access && busy;
   assign win_rdata  = busy ? 32'h0 : words[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx <= '0;
      else if (mode_wr || idx_clr) idx <= '0;
      else if (win_go)             idx <= (idx == last_idx) ? '0 : idx + 1'b1;
   end

   for (genvar i = 0; i < WIDE_WORDS; i++) begin : g_word
      localparam logic [31:0] IV = IV_SEED ^ (32'(i) * 32'h01010101);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i] <= IV;
         end else if (mode_wr) begin
            words[i] <= IV;
         end else if (fin_done) begin
            if (IDXW'(i) <= last_idx) words[i] <= words[i] ^ len_lo;
         end else begin
            if (win_wr && win_go && idx == IDXW'(i)) words[i] <= win_wdata;
            if (beat_ok && beat_idx == IDXW'(i))     words[i] <= words[i] + beat_data;
         end
      end
   end

   // R4
   idx_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr || idx_clr) |=> (idx == '0));
   // R8
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_err && !mode_wr && !idx_clr) |=> $stable(idx));
   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= last_idx || $past(mode_wr));
endmodule

// File: rtl/hash_ctl_irq.sv
module hash_ctl_irq #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic            clr_wr,
   input  logic            en_wr,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] isr,
   output logic [NSRC-1:0] ier,
   output logic            irq
);
   logic [NSRC-1:0] clr_mask;
   assign clr_mask = clr_wr ? wdata : '0;
   assign irq      = |(isr & ier);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr <= '0;
         ier <= '0;
      end else begin
         isr <= (isr & ~clr_mask) | set_vec;
         if (en_wr) ier <= wdata;
      end
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_chk
      // R10
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && wdata[k] && !set_vec[k]) |=> !isr[k]);
      // R10
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (isr[k] && !clr_mask[k]) |=> isr[k]);
   end
   // R10
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == '0) |-> !irq);
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
   import hash_ctl_pkg::*;
#(
   parameter int          NARROW_WORDS = 8,
   parameter int          WIDE_WORDS   = 16,
   parameter int          FINAL_CYCLES = 4,
   parameter logic [31:0] IV_SEED      = 32'h5A5A0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [7:0]  req_addr,
   input  logic [31:0] req_wdata,
   output logic [31:0] rsp_rdata,
   input  logic        beat_valid,
   input  logic [31:0] beat_data,
   output logic        irq
);
   if (NARROW_WORDS < 2 || (NARROW_WORDS & (NARROW_WORDS - 1)) != 0 ||
       WIDE_WORDS < NARROW_WORDS || (WIDE_WORDS & (WIDE_WORDS - 1)) != 0 ||
       FINAL_CYCLES < 1) begin : g_bad_cfg
      $error("hash_ctl_regs: word counts must be powers of two, narrow <= wide, FINAL_CYCLES >= 1");
   end

   logic wr, rd;
   assign wr = req_valid && req_write;
   assign rd = req_valid && !req_write;

   mode_t mode_q;
   logic  mode_wr, op_wr;
   assign mode_wr = wr && (req_addr == OFS_MODE);
   assign op_wr   = wr && (req_addr == OFS_OP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= '{order: req_wdata[31:26],
                                    keyed: req_wdata[22],
                                    alg:   req_wdata[18:16]};
   end

   logic        busy, beat_ok, fin_done, err_orphan, err_term, win_err;
   logic [31:0] len_lo, len_hi, win_rdata;

   hash_ctl_engine #(.FINAL_CYCLES(FINAL_CYCLES), .BEAT_BYTES(4)) u_engine (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
      .op_start(op_wr && req_wdata[0]), .op_term(op_wr && req_wdata[1]),
      .beat_valid(beat_valid),
      .len_lo_wr(wr && (req_addr == OFS_LENLO)),
      .len_hi_wr(wr && (req_addr == OFS_LENHI)),
      .wdata(req_wdata), .busy(busy), .beat_ok(beat_ok), .fin_done(fin_done),
      .err_orphan(err_orphan), .err_term(err_term),
      .len_lo(len_lo), .len_hi(len_hi));

   hash_ctl_state #(.NARROW_WORDS(NARROW_WORDS), .WIDE_WORDS(WIDE_WORDS),
                    .IV_SEED(IV_SEED)) u_state (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
      .wide(alg_is_wide(mode_q.alg)), .idx_clr(op_wr),
      .win_rd(rd && (req_addr == OFS_CHAIN)),
      .win_wr(wr && (req_addr == OFS_CHAIN)),
      .win_wdata(req_wdata), .busy(busy), .beat_ok(beat_ok),
      .beat_data(beat_data), .len_lo(len_lo), .fin_done(fin_done),
      .win_rdata(win_rdata), .win_err(win_err));

   logic [NUM_IRQ-1:0] set_vec, isr, ier;
   always_comb begin
      set_vec              = '0;
      set_vec[IRQ_ORPHAN]  = err_orphan;
      set_vec[IRQ_WINBUSY] = win_err;
      set_vec[IRQ_DONE]    = fin_done;
      set_vec[IRQ_BADTERM] = err_term;
   end

   hash_ctl_irq #(.NSRC(NUM_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_wr(wr && (req_addr == OFS_ISR)),
      .en_wr(wr && (req_addr == OFS_IER)),
      .wdata(req_wdata[NUM_IRQ-1:0]),
      .isr(isr), .ier(ier), .irq(irq));

   always_comb begin
      rsp_rdata = '0;
      if (rd) begin
         case (req_addr)
            OFS_MODE:  rsp_rdata = {mode_q.order, 3'b0, mode_q.keyed, 3'b0,
                                    mode_q.alg, 16'b0};
            OFS_CHAIN: rsp_rdata = win_rdata;
            OFS_ISR:   rsp_rdata = 32'(isr);
            OFS_IER:   rsp_rdata = 32'(ier);
            OFS_STAT:  rsp_rdata = {31'b0, busy};
            OFS_LENLO: rsp_rdata = len_lo;
            OFS_LENHI: rsp_rdata = len_hi;
            default:   rsp_rdata = '0;
         endcase
      end
   end

   // R7
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr[IRQ_DONE]) |-> $past(busy));
   // R8
   win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr == OFS_CHAIN && busy) |-> (rsp_rdata == 32'h0));
endmodule

// File: tb/hash_ctl_regs_test.sv
`timescale 1ns/1ps
module hash_ctl_regs_test;
   localparam logic [31:0] SEED = 32'h5A5A0000;
   localparam logic [7:0] A_MODE = 8'h00, A_CHAIN = 8'h04, A_OP = 8'h08,
      A_ISR = 8'h50, A_IER = 8'h54, A_STAT = 8'h58, A_LLO = 8'h60, A_LHI = 8'h64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        beat_valid = 1'b0;
   logic [31:0] beat_data = '0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   logic [31:0] mw [16];
   logic [63:0] mlen;
   int          mnw;

   always #5 clk = ~clk;

   hash_ctl_regs uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .beat_valid(beat_valid), .beat_data(beat_data), .irq(irq));

   function automatic logic [31:0] iv(input int i);
      return SEED ^ (32'(i) * 32'h01010101);
   endfunction

   task automatic model_reset(input int alg);
      for (int i = 0; i < 16; i++) mw[i] = iv(i);
      mlen = '0;
      mnw  = (alg == 3 || alg == 4) ? 16 : 8;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] r);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      #1 r = rsp_rdata;
      @(posedge clk);
      #1 req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] r;
      bus(1'b1, a, d, r);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] r);
      bus(1'b0, a, 32'h0, r);
   endtask

   task automatic beat(input logic [31:0] d, input bit act);
      @(negedge clk);
      beat_valid = 1'b1; beat_data = d;
      @(posedge clk);
      #1 beat_valid = 1'b0;
      if (act) begin
         int j;
         j = int'((mlen[31:0] >> 2) & 32'(mnw - 1));
         mw[j] = mw[j] + d;
         mlen = mlen + 64'd4;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #1000000;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      model_reset(0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_MODE, r); chk("R1 mode", r, 0);
      rd(A_LLO, r);  chk("R1 len_lo", r, 0);
      rd(A_LHI, r);  chk("R1 len_hi", r, 0);
      rd(A_ISR, r);  chk("R1 isr", r, 0);
      rd(A_IER, r);  chk("R1 ier", r, 0);
      rd(A_STAT, r); chk("R1 status", r, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      for (int j = 0; j < 9; j++) begin
         rd(A_CHAIN, r); chk("R1 R3 initial word", r, iv(j % 8));
      end

      // R2 R3 sweep over every algorithm code
      for (int a = 0; a < 8; a++) begin
         wr(A_LLO, 32'h10);
         wr(A_MODE, (32'(a) << 16) | (32'h1 << 22) | (32'h2A << 26) | 32'h1);
         model_reset(a);
         rd(A_MODE, r);
         chk("R2 mode readback", r, (32'(a) << 16) | (32'h1 << 22) | (32'h2A << 26));
         rd(A_LLO, r); chk("R2 len cleared", r, 0);
         for (int j = 0; j <= mnw; j++) begin
            rd(A_CHAIN, r); chk("R3 window walk", r, iv(j % mnw));
         end
      end

      // R4 window position reset by operation write
      wr(A_MODE, 32'h1 << 16); model_reset(1);
      repeat (3) rd(A_CHAIN, r);
      wr(A_OP, 32'h0);
      rd(A_CHAIN, r); chk("R4 op write homes window", r, iv(0));
      rd(A_CHAIN, r);
      wr(A_MODE, 32'h1 << 16);
      rd(A_CHAIN, r); chk("R4 mode write homes window", r, iv(0));

      // R5 active beats
      wr(A_OP, 32'h1);
      for (int k = 0; k < 10; k++) beat(32'h10000001 * 32'(k + 1) + 32'(k), 1'b1);
      rd(A_LLO, r);  chk("R5 len_lo", r, mlen[31:0]);
      rd(A_LHI, r);  chk("R5 len_hi", r, mlen[63:32]);
      rd(A_ISR, r);  chk("R7 no done on partial update", r, 0);
      rd(A_STAT, r); chk("R5 not busy while active", r, 0);
      for (int j = 0; j < 8; j++) begin
         rd(A_CHAIN, r); chk("R5 state word", r, mw[j]);
      end

      // R7 R8 terminate and finalization window
      wr(A_OP, 32'h2);
      rd(A_STAT, r);  chk("R7 busy cycle 1", r, 1);
      rd(A_CHAIN, r); chk("R8 window reads zero while busy", r, 0);
      rd(A_STAT, r);  chk("R7 busy cycle 3", r, 1);
      rd(A_STAT, r);  chk("R7 busy cycle 4", r, 1);
      rd(A_STAT, r);  chk("R7 busy ends", r, 0);
      rd(A_ISR, r);   chk("R7 R8 done and window error", r, 32'h6);
      for (int j = 0; j < 8; j++) mw[j] = mw[j] ^ mlen[31:0];
      for (int j = 0; j < 8; j++) begin
         rd(A_CHAIN, r); chk("R7 R8 final word, position held", r, mw[j]);
      end

      // R10 write-one-to-clear
      wr(A_ISR, 32'h2);
      rd(A_ISR, r); chk("R10 clear one bit", r, 32'h4);
      wr(A_ISR, 32'hF);
      rd(A_ISR, r); chk("R10 clear all", r, 0);

      // R6 orphan beat
      beat(32'hDEADBEEF, 1'b0);
      rd(A_LLO, r);   chk("R6 len unchanged", r, mlen[31:0]);
      rd(A_CHAIN, r); chk("R6 word unchanged", r, mw[0]);
      rd(A_ISR, r);   chk("R6 orphan flag", r, 32'h1);

      // R9 terminate without active operation
      wr(A_OP, 32'h2);
      rd(A_STAT, r); chk("R9 no busy", r, 0);
      rd(A_ISR, r);  chk("R9 bad terminate flag", r, 32'h9);
      wr(A_ISR, 32'hF);

      // R11 context restore in the wide family, carry into high length
      wr(A_MODE, 32'h3 << 16); model_reset(3);
      for (int j = 0; j < 16; j++) begin
         mw[j] = 32'hA5000000 + 32'(j * 7919);
         wr(A_CHAIN, mw[j]);
      end
      wr(A_LLO, 32'hFFFFFFFC); wr(A_LHI, 32'h5);
      mlen = {32'h5, 32'hFFFFFFFC};
      wr(A_OP, 32'h1);
      beat(32'h01020304, 1'b1);
      beat(32'h11111111, 1'b1);
      rd(A_LLO, r); chk("R11 len_lo after carry", r, 32'h4);
      rd(A_LHI, r); chk("R11 len_hi after carry", r, 32'h6);
      wr(A_OP, 32'h2);
      rd(A_CHAIN, r); chk("R8 wide window zero while busy", r, 0);
      for (int n = 0; n < 20; n++) begin
         rd(A_STAT, r);
         if (r[0] == 1'b0) break;
      end
      chk("R7 wide finalization ends", r, 0);
      for (int j = 0; j < 16; j++) mw[j] = mw[j] ^ mlen[31:0];
      for (int j = 0; j < 16; j++) begin
         rd(A_CHAIN, r); chk("R11 R3 restored wide word", r, mw[j]);
      end
      rd(A_ISR, r); chk("R7 wide done", r, 32'h6);

      // R10 enable sweep and bit-by-bit clear
      beat(32'h1, 1'b0);
      wr(A_OP, 32'h2);
      rd(A_ISR, r); chk("R10 all status set", r, 32'hF);
      for (int v = 0; v < 16; v++) begin
         wr(A_IER, 32'(v));
         #1 chk("R10 irq vs enable", {31'b0, irq}, (v != 0) ? 32'h1 : 32'h0);
         rd(A_IER, r); chk("R10 enable readback", r, 32'(v));
      end
      for (int k = 0; k < 4; k++) begin
         wr(A_ISR, 32'h1 << k);
         rd(A_ISR, r); chk("R10 sequential clear", r, 32'hF & ~((32'h2 << k) - 32'h1));
         chk("R10 irq while clearing", {31'b0, irq}, (k < 3) ? 32'h1 : 32'h0);
      end

      finish_run();
   end
endmodule